// File: doc/BRIEF.md
# Multiplexed Address/Data External Bus Master

This block lets on-chip logic reach external SRAM or memory-mapped peripherals through a narrow shared bus. One 16-bit bus carries both the address and the data, at different times. Each access starts with an address phase. During that phase the controller drives the upper address bits and pulses an address-latch strobe, so that an external latch captures them. The data phase follows, with an active-low read or write strobe. The external device may be 8 bits wide, with an address reach of 24 bits. It may also be 16 bits wide, with an address reach of 16 bits. The width is chosen per request.

Requests enter on a valid/ready handshake that carries the address, write data, direction and width. `req_ready` is the only form of back-pressure. It is high while the controller is idle and during the last cycle of a transfer, and low for the rest of a transfer. A request is taken on any clock edge where `req_valid` and `req_ready` are both high. The request fields must stay stable while `req_valid` is high and `req_ready` is low.

Read data comes back as a single-cycle `rsp_valid` pulse. The response side has no ready input, so the consumer must accept the word in that cycle. A wait count is sampled with each request and lengthens the strobe. The bus is described as separate out, in and per-byte-lane output-enable signals, and the pad is left to the chip top.

Top module: `pbus_ctrl`

## Requirements
- R1: During and right after reset: `ale`=0, `rd_n`=`wr_n`=1, `ad_oe`=00, `rsp_valid`=0, `req_ready`=1.
- R2: `req_ready` is 1 in the idle state and in the last (recovery) cycle of a transfer, and 0 in every other transfer cycle. A request is accepted on an edge where `req_valid` and `req_ready` are both 1.
- R3: `ale` is 1 for exactly the first cycle after acceptance, with both lanes driven (`ad_oe`=11). `ad_out` holds `addr[15:0]` in 16-bit mode (`req_wide`=1) and `addr[23:8]` in 8-bit mode. In the next cycle `ale` is 0 and the same address is still driven. An external latch that captures on the falling edge of `ale` therefore holds that value.
- R4: `rd_n` and `wr_n` are never both 0, and neither is 0 while `ale` is 1.
- R5: The strobe (`rd_n` when `req_write`=0, `wr_n` when `req_write`=1) is 0 from the third cycle after acceptance for 1+`cfg_wait` cycles. `cfg_wait` is sampled at acceptance, and later changes to it do not affect the transfer in flight.
- R6: For a 16-bit write, `ad_out` equals the write data, with both lanes enabled, during the strobe and the recovery cycle.
- R7: In 8-bit mode, the data phase drives `addr[7:0]` on `ad_out[15:8]`, with lane 1 enabled. A write places `wdata[7:0]` on `ad_out[7:0]`.
- R8: During a read, the data lanes are released for the strobe and recovery cycles: `ad_oe`=00 in 16-bit mode and `ad_oe`=10 in 8-bit mode.
- R9: Read data is sampled from `ad_in` on the edge that ends the last strobe cycle. `rsp_valid` is 1 for the single following cycle, with `rsp_data` = `ad_in` in 16-bit mode and `{8'h00, ad_in[7:0]}` in 8-bit mode.
- R10: If a request is accepted in a recovery cycle, its `ale` follows in the next cycle. The request-to-request period is therefore 4+`cfg_wait` cycles.
- R11: A write never produces `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wait | input | WAIT_W | Extra strobe cycles, sampled per request |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | 24 | External address |
| req_wdata | input | 16 | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit device, 0 = 8-bit device |
| rsp_valid | output | 1 | One-cycle read-data pulse |
| rsp_data | output | 16 | Read data |
| ad_out | output | 16 | Bus value driven when enabled |
| ad_oe | output | 2 | Per-byte-lane output enable (bit 1 = ad[15:8]) |
| ad_in | input | 16 | Bus value seen at the pad |
| ale | output | 1 | Address latch enable, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
Random reads and writes mix both widths, wait counts of 0 to 15, back-to-back chaining and idle gaps. These separate the phase sequencing and the strobe length from the lane muxing. In directed cases, `cfg_wait` and the request fields are scrambled right after acceptance, which shows that the values in use are the ones latched at acceptance. During early strobe cycles the bench drives the complement of the final read value on `ad_in`, so a read sampled a cycle too early shows up. Non-zero upper bytes in 8-bit reads expose missing masking. A latch model captures `ad_out` on the falling edge of `ale` and rebuilds the full address from the latched value and the data-phase address byte.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  parameter int AD_W   = 16;
  parameter int ADDR_W = 24;
  parameter int LANE_W = 8;
  localparam int LANES = AD_W / LANE_W;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ALE, PH_HOLD, PH_STRB, PH_REC
  } phase_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [AD_W-1:0]   wdata;
    logic              write;
    logic              wide;
  } req_t;
endpackage

// File: rtl/pbus_seq.sv
module pbus_seq
  import pbus_pkg::*;
#(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WAIT_W-1:0] cfg_wait,
  input  logic              req_valid,
  output logic              req_ready,
  output logic              accept,
  output logic              last_strb,
  output phase_e            phase
);
  logic [WAIT_W-1:0] wait_lat;
  logic [WAIT_W-1:0] cnt;
  phase_e            nxt;

  assign req_ready = (phase == PH_IDLE) || (phase == PH_REC);
  assign accept    = req_valid && req_ready;
  assign last_strb = (phase == PH_STRB) && (cnt == '0);

  always_comb begin
    nxt = phase;
    unique case (phase)
      PH_IDLE: if (accept) nxt = PH_ALE;
      PH_ALE:  nxt = PH_HOLD;
      PH_HOLD: nxt = PH_STRB;
      PH_STRB: if (cnt == '0) nxt = PH_REC;
      PH_REC:  nxt = accept ? PH_ALE : PH_IDLE;
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      wait_lat <= '0;
      cnt      <= '0;
    end else begin
      phase <= nxt;
      if (accept) wait_lat <= cfg_wait;
      if (phase == PH_HOLD) cnt <= wait_lat;
      else if (phase == PH_STRB && cnt != '0) cnt <= cnt - 1'b1;
    end
  end

  // R5: strobe phase is always entered from the hold phase, after the address
  assert_strb_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HOLD) |=> (phase == PH_STRB));
  // R2: a transfer in its address phase cannot take another request
  assert_busy_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ALE || phase == PH_HOLD) |-> !req_ready);
endmodule

// File: rtl/pbus_lanes.sv
module pbus_lanes
  import pbus_pkg::*;
(
  input  phase_e          phase,
  input  req_t            req,
  output logic [AD_W-1:0] ad_out,
  output logic [LANES-1:0] ad_oe
);
  logic addr_ph, data_ph;
  assign addr_ph = (phase == PH_ALE) || (phase == PH_HOLD);
  assign data_ph = (phase == PH_STRB) || (phase == PH_REC);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam bit TOP = (l == LANES - 1);
    logic [LANE_W-1:0] a_byte, d_byte;
    logic              d_oe;
    if (TOP) begin : g_top
      // narrow mode: top lane carries the low address byte during data
      assign a_byte = req.wide ? req.addr[l*LANE_W +: LANE_W]
                               : req.addr[(l+1)*LANE_W +: LANE_W];
      assign d_byte = req.wide ? req.wdata[l*LANE_W +: LANE_W]
                               : req.addr[LANE_W-1:0];
      assign d_oe   = req.write || !req.wide;
    end else begin : g_low
      assign a_byte = req.wide ? req.addr[l*LANE_W +: LANE_W]
                               : req.addr[(l+1)*LANE_W +: LANE_W];
      assign d_byte = req.wdata[l*LANE_W +: LANE_W];
      assign d_oe   = req.write;
    end
    assign ad_out[l*LANE_W +: LANE_W] = addr_ph ? a_byte :
                                        data_ph ? d_byte : '0;
    assign ad_oe[l] = addr_ph || (data_ph && d_oe);
  end
endmodule

// File: rtl/pbus_ctrl.sv
module pbus_ctrl
  import pbus_pkg::*;
#(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WAIT_W-1:0] cfg_wait,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [23:0]       req_addr,
  input  logic [15:0]       req_wdata,
  input  logic              req_write,
  input  logic              req_wide,
  output logic              rsp_valid,
  output logic [15:0]       rsp_data,
  output logic [15:0]       ad_out,
  output logic [1:0]        ad_oe,
  input  logic [15:0]       ad_in,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n
);
  phase_e phase;
  logic   accept, last_strb;
  req_t   cur;

  pbus_seq #(.WAIT_W(WAIT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cfg_wait(cfg_wait), .req_valid(req_valid),
    .req_ready(req_ready), .accept(accept), .last_strb(last_strb),
    .phase(phase)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= '0;
    else if (accept) cur <= '{addr: req_addr, wdata: req_wdata,
                              write: req_write, wide: req_wide};
  end

  pbus_lanes u_lanes (.phase(phase), .req(cur), .ad_out(ad_out), .ad_oe(ad_oe));

  assign ale  = (phase == PH_ALE);
  assign rd_n = !((phase == PH_STRB) && !cur.write);
  assign wr_n = !((phase == PH_STRB) &&  cur.write);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= last_strb && !cur.write;
      if (last_strb && !cur.write)
        rsp_data <= cur.wide ? ad_in : {{(AD_W-LANE_W){1'b0}}, ad_in[LANE_W-1:0]};
    end
  end

  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
  assert_no_strobe_on_ale_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (rd_n && wr_n));
  assert_ale_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);
  assert_ale_drives_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (ad_oe == 2'b11));
  assert_strobe_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> !req_ready);
  assert_read_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe[0]);
  assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  assert_rsp_after_rd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $rose(rd_n));
  assert_write_norsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> !rsp_valid);
endmodule

// File: tb/pbus_ctrl_bench.sv
module pbus_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_wait = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_write = 1'b0;
  logic        req_wide = 1'b0;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic [15:0] ad_out;
  logic [1:0]  ad_oe;
  logic [15:0] ad_in = '0;
  logic        ale, rd_n, wr_n;
  logic [15:0] latched = '0;
  int vectors = 0;
  int fails = 0;

  always #2 clk = ~clk;

  pbus_ctrl u_pbus_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_wait(cfg_wait), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_write(req_write), .req_wide(req_wide), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n)
  );

  // external address latch model
  always @(negedge ale) latched = ad_out;

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] exp_abus(logic [23:0] a, bit wd);
    return wd ? a[15:0] : a[23:8];
  endfunction
  function automatic logic [15:0] exp_dbus(logic [23:0] a, logic [15:0] d, bit wd);
    return wd ? d : {a[7:0], d[7:0]};
  endfunction
  function automatic logic [1:0] exp_oe(bit w, bit wd);
    return w ? 2'b11 : (wd ? 2'b00 : 2'b10);
  endfunction
  function automatic logic [15:0] exp_rsp(logic [15:0] v, bit wd);
    return wd ? v : {8'h00, v[7:0]};
  endfunction
  function automatic logic [15:0] lane_mask(logic [1:0] oe);
    return {{8{oe[1]}}, {8{oe[0]}}};
  endfunction

  // called at a negedge where req_ready is expected high; returns at the
  // negedge of the recovery cycle
  task automatic txn(input logic [23:0] a, input logic [15:0] d,
                     input bit w, input bit wd, input logic [3:0] wt);
    logic [15:0] rdv, m;
    logic [23:0] recon;
    rdv = 16'($urandom);
    cfg_wait = wt; req_addr = a; req_wdata = d; req_write = w; req_wide = wd;
    req_valid = 1'b1;
    check(req_ready == 1'b1, "R2 ready before accept", 32'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    cfg_wait = ~wt;                       // R5: must be ignored now
    req_addr = ~a; req_wdata = ~d; req_write = ~w; req_wide = ~wd;
    check(ale == 1'b1, "R3 ale first cycle", 32'(ale), 1);
    check(ad_out == exp_abus(a, wd), "R3 address phase", 32'(ad_out), 32'(exp_abus(a, wd)));
    check(ad_oe == 2'b11, "R3 address lanes", 32'(ad_oe), 3);
    check(rd_n && wr_n, "R4 no strobe with ale", 32'({rd_n, wr_n}), 3);
    check(req_ready == 1'b0, "R2 busy in ale", 32'(req_ready), 0);
    @(negedge clk);
    check(ale == 1'b0 && ad_out == exp_abus(a, wd), "R3 address hold",
          32'({ale, ad_out}), 32'({1'b0, exp_abus(a, wd)}));
    check(rd_n && wr_n && !req_ready, "R5 no strobe in hold",
          32'({rd_n, wr_n, req_ready}), 6);
    for (int i = 0; i <= int'(wt); i++) begin
      @(negedge clk);
      check(rd_n == w && wr_n == !w, "R5 strobe active",
            32'({rd_n, wr_n}), 32'({w, !w}));
      check(!req_ready && !rsp_valid, "R2 busy in strobe",
            32'({req_ready, rsp_valid}), 0);
      check(ad_oe == exp_oe(w, wd), w ? "R6 write lanes" : "R8 read release",
            32'(ad_oe), 32'(exp_oe(w, wd)));
      m = lane_mask(exp_oe(w, wd));
      check((ad_out & m) == (exp_dbus(a, d, wd) & m), wd ? "R6 data bus" : "R7 narrow data bus",
            32'(ad_out & m), 32'(exp_dbus(a, d, wd) & m));
      if (i == 0) begin
        recon = wd ? {8'h00, latched} : {latched, ad_out[15:8]};
        check(recon == (wd ? {8'h00, a[15:0]} : a), "R7 latched address",
              32'(recon), 32'(wd ? {8'h00, a[15:0]} : a));
      end
      ad_in = (i == int'(wt)) ? rdv : ~rdv;
    end
    @(negedge clk);
    check(rd_n && wr_n, "R5 strobe ends", 32'({rd_n, wr_n}), 3);
    check(req_ready == 1'b1, "R2 ready in recovery", 32'(req_ready), 1);
    check(rsp_valid == !w, w ? "R11 no write response" : "R9 read pulse",
          32'(rsp_valid), 32'(!w));
    if (!w)
      check(rsp_data == exp_rsp(rdv, wd), "R9 read data", 32'(rsp_data),
            32'(exp_rsp(rdv, wd)));
    else
      check(ad_out == exp_dbus(a, d, wd) && ad_oe == 2'b11, "R6 write hold",
            32'(ad_out), 32'(exp_dbus(a, d, wd)));
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    check(req_ready && !ale && rd_n && wr_n && ad_oe == 2'b00 && !rsp_valid,
          "R1 idle outputs", 32'({req_ready, ale, rd_n, wr_n, ad_oe, rsp_valid}),
          32'(7'b1011000));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (2) @(negedge clk);
    check(!ale && rd_n && wr_n && ad_oe == 2'b00 && !rsp_valid && req_ready,
          "R1 reset state", 32'({req_ready, ale, rd_n, wr_n, ad_oe, rsp_valid}),
          32'(7'b1011000));
    rst_n = 1'b1;
    idle_cycle();
    // directed corners
    txn(24'hABCDEF, 16'h1234, 1'b1, 1'b1, 4'd0);
    txn(24'h123456, 16'h00A5, 1'b0, 1'b1, 4'd0);   // R10 chained
    txn(24'hFEDCBA, 16'h5A5A, 1'b0, 1'b0, 4'd15);  // R10 chained, max wait
    txn(24'h00FF01, 16'hC3C3, 1'b1, 1'b0, 4'd3);
    idle_cycle();
    txn(24'h800000, 16'hFFFF, 1'b0, 1'b0, 4'd1);
    idle_cycle();
    // random mix
    for (int n = 0; n < 120; n++) begin
      txn(24'($urandom), 16'($urandom), 1'($urandom), 1'($urandom),
          4'($urandom));
      if ($urandom % 2 == 0) begin
        for (int k = 0; k <= int'($urandom % 2); k++) idle_cycle();
      end
    end
    idle_cycle();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(4 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule